// File: doc/BRIEF.md
# Dithered Two-Channel Phase-Correct PWM

This block drives two LED channels from one 8-bit phase-correct PWM timebase. It gets close to 15-bit brightness resolution by dithering the duty cycle from one period to the next. Each channel level is split into two fields:

- an 8-bit base duty;
- a 7-bit fraction.

Once per PWM period the fraction is added into a per-channel error accumulator. The carry out of that sum adds one count to the duty of a later period. Over 128 periods the average duty therefore moves in steps of 1/128 count.

Both channels share one up/down counter, so their period and phase are identical. The duty for each period is worked out during the period before it and is moved into the compare register at the period boundary. This is a one-period pipeline.

A load strobe takes new levels for both channels and applies the base duty at once, for a fast response during strobing effects. A zero command turns both outputs off immediately.

Top module: `dsm_pwm`

## Requirements
- R1: A synchronous active-low reset clears the phase counter, the accumulators, the stored levels, the pending duties and the compare values. While reset is held and during the first period after it, with no load, both outputs are low. The period after reset starts at phase 0.
- R2: The shared phase runs 0..511 and wraps, so a period is 512 clocks. The counter value counts 0..255 up through phases 0..255, then 255..0 down through phases 256..511. An output is high while the counter value is below the channel compare value. A high pulse is therefore 2×compare clocks wide and centred on the period boundary. For compare 10, the output is high at phases 0..9 and 502..511 and low at phases 10..501, on both channels at the same moments.
- R3: The compare value is 9 bits wide and ranges from 0 to 256. A compare of 0 keeps the output low for the whole period. A compare of 256 keeps it high for the whole period (512 high clocks). A compare of 255 gives 510 high clocks.
- R4: Each channel takes a 16-bit field of `level_i`; channel 0 uses bits [15:0] and channel 1 uses bits [31:16]. Within a field, bits [14:7] are the base duty and bits [6:0] are the fraction. Bit 15 of each field has no effect.
- R5: In the clock where `load_i` is high, each channel sets both its compare value and its pending duty to the base duty of its new level. The output follows the new compare value from the next clock, even mid-period.
- R6: At each period boundary (the clock where the phase goes from 511 to 0) with no load or zero in that clock, each channel does three things:
  - it adds its fraction to the 7-bit accumulator;
  - it sets the pending duty to base + 1 when the sum exceeds 127, and to base otherwise;
  - it keeps the sum modulo 128.
  
  Over any 128 consecutive boundaries the number of +1 periods equals the fraction.
- R7: At a period boundary the compare value takes the pending duty computed at the previous boundary (or set by the last load) before the new pending duty is formed. Starting from a cleared accumulator with fraction 127 and base 20 loaded mid-period, the next four periods have compare values 20, 20, 21, 21.
- R8: A load or a zero command leaves the accumulators unchanged. In a clock that is both a period boundary and a load, the load takes effect and no accumulation happens.
- R9: In the clock where `zero_i` is high, both stored levels, both pending duties and both compare values are cleared, so both outputs are low from the next clock and in the following periods. `zero_i` takes priority over `load_i`.
- R10: A change on `level_i` while `load_i` is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Strobe: take `level_i` for both channels and apply the base duty at once |
| zero_i | input | 1 | Strobe: clear both channels, outputs low |
| level_i | input | 32 | Channel 0 level in [15:0], channel 1 level in [31:16] |
| pwm_o | output | 2 | PWM outputs, bit 0 for channel 0 and bit 1 for channel 1 |

## Verification
The bench applies several level patterns, each chosen to separate a particular wrong design:

- **Zero fraction.** Gives a fixed duty, which exposes compare and counter-shape errors. It is sampled at the edges of the pulse to confirm that the pulse is centred.
- **Fraction 127 from a cleared accumulator.** The exact sequence of per-period widths separates the one-period pipeline from a direct update, and a carry on sums above 127 from a carry on sums of 127 or more.
- **Reload mid-period with a fraction of 100.** Shows that a load keeps the accumulator contents and overwrites the pending duty.
- **Fraction 37 and fraction 90, summed over 128 periods.** The total high time must match the fraction exactly.
- **Full-scale levels.** Reach compare 255 and 256, which shows whether the ninth compare bit is kept.
- **Bit 15 set, zero strobes and unloaded level changes.** Checked for having no effect at the outputs, or for the effect R9 defines.

// File: rtl/dsm_pwm_pkg.sv
// Package: shared constants and the per-channel command type for the
// dithered PWM. Assumes the command is decoded once at the top and
// broadcast to every channel.
package dsm_pwm_pkg;

    localparam int DEF_DUTY_W = 8;
    localparam int DEF_FRAC_W = 7;
    localparam int DEF_NCH    = 2;

    // Channel command, priority already resolved by the decoder.
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_ZERO = 2'd3
    } chan_cmd_e;

endpackage

// File: rtl/dsm_pwm_phase.sv
// Module: shared phase-correct timebase.
// A free-running phase of DUTY_W+1 bits is folded into an up/down count:
// the first half counts 0..MAX up, the second half MAX..0 down, so a
// period lasts 2^(DUTY_W+1) clocks. period_end flags the last phase.
// Assumes divide-by-one clocking (one phase step per clock).
module dsm_pwm_phase #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              period_end_o
);

    localparam int PH_W = DUTY_W + 1;
    localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

    logic [PH_W-1:0] phase_q;

    // Advance the phase every clock; reset starts the period at phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Fold the phase into the triangular counter value.
    always_comb begin
        if (phase_q[PH_W-1]) begin
            cnt_o = ~phase_q[DUTY_W-1:0];
        end else begin
            cnt_o = phase_q[DUTY_W-1:0];
        end
    end

    // Flag the final clock of the period (next edge is the boundary).
    assign period_end_o = (phase_q == PH_MAX);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MAX) |=> (phase_q == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_MAX) |=> (phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/dsm_pwm_compare.sv
// Module: output comparator for one channel.
// Drives the PWM pin high while the shared counter is below the compare
// value. The compare value is one bit wider than the counter so that
// MAX+1 yields a constant-high period. Purely combinational.
module dsm_pwm_compare #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] cnt_i,
    input  logic [DUTY_W:0]   cmp_i,
    output logic              pwm_o
);

    // Widen the counter and compare against the 9-bit duty.
    always_comb begin
        pwm_o = ({1'b0, cnt_i} < cmp_i);
    end

endmodule

// File: rtl/dsm_pwm_chan.sv
// Module: one dithered PWM channel.
// Holds the stored level, the fraction accumulator, the pending duty for
// the next period and the active compare value. On CMD_STEP (period
// boundary) the pending duty moves into the compare register first, then
// the fraction is accumulated and the next pending duty is formed from
// the carry. CMD_LOAD applies the new base duty at once without touching
// the accumulator; CMD_ZERO clears level, pending and compare.
// Assumes the command is already priority-resolved.
module dsm_pwm_chan
    import dsm_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int FRAC_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  chan_cmd_e                cmd_i,
    input  logic [DUTY_W+FRAC_W-1:0] level_i,
    output logic [DUTY_W:0]          cmp_o
);

    localparam int LV_W  = DUTY_W + FRAC_W;
    localparam int CMP_W = DUTY_W + 1;
    localparam logic [CMP_W-1:0] CMP_MAX = {1'b1, {DUTY_W{1'b0}}};

    logic [LV_W-1:0]   level_q;
    logic [FRAC_W-1:0] acc_q;
    logic [CMP_W-1:0]  pend_q;
    logic [CMP_W-1:0]  cmp_q;

    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [CMP_W-1:0]  pend_next;
    logic [CMP_W-1:0]  load_base;

    // Accumulate the stored fraction and extract the carry.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, level_q[FRAC_W-1:0]};
        carry   = acc_sum[FRAC_W];
    end

    // Next period duty: stored base plus the dither carry.
    always_comb begin
        pend_next = {1'b0, level_q[LV_W-1:FRAC_W]} + {{DUTY_W{1'b0}}, carry};
    end

    // Base duty of the incoming level for an immediate load.
    always_comb begin
        load_base = {1'b0, level_i[LV_W-1:FRAC_W]};
    end

    // Channel state update per resolved command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            acc_q   <= '0;
            pend_q  <= '0;
            cmp_q   <= '0;
        end else begin
            case (cmd_i)
                CMD_ZERO: begin
                    level_q <= '0;
                    pend_q  <= '0;
                    cmp_q   <= '0;
                end
                CMD_LOAD: begin
                    level_q <= level_i;
                    pend_q  <= load_base;
                    cmp_q   <= load_base;
                end
                CMD_STEP: begin
                    cmp_q  <= pend_q;
                    pend_q <= pend_next;
                    acc_q  <= acc_sum[FRAC_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    assign cmp_o = cmp_q;

    assert_cmp_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q <= CMP_MAX));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> (cmp_q == {1'b0, $past(level_i[LV_W-1:FRAC_W])}));

    assert_pipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STEP) |=> (cmp_q == $past(pend_q)));

    assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_STEP) |=> $stable(acc_q));

    assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ZERO) |=> (cmp_q == '0 && pend_q == '0));

endmodule

// File: rtl/dsm_pwm.sv
// Module: top of the dithered multi-channel phase-correct PWM.
// Owns the shared timebase, resolves the strobes into one command per
// clock (zero over load over period boundary) and instantiates one
// channel and one comparator per output. Each level field is
// DUTY_W+FRAC_W+1 bits wide; its top bit is spare and ignored.
module dsm_pwm
    import dsm_pwm_pkg::*;
#(
    parameter int NCH    = DEF_NCH,
    parameter int DUTY_W = DEF_DUTY_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_i,
    input  logic                                zero_i,
    input  logic [NCH*(DUTY_W+FRAC_W+1)-1:0]    level_i,
    output logic [NCH-1:0]                      pwm_o
);

    localparam int LV_W  = DUTY_W + FRAC_W;
    localparam int FLD_W = LV_W + 1;

    logic [DUTY_W-1:0] cnt;
    logic              period_end;
    chan_cmd_e         cmd;
    logic [NCH-1:0]    unused_spare;

    // Shared up/down counter for all channels.
    dsm_pwm_phase #(
        .DUTY_W (DUTY_W)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_o        (cnt),
        .period_end_o (period_end)
    );

    // Resolve strobe priority into one broadcast command.
    always_comb begin
        if (zero_i) begin
            cmd = CMD_ZERO;
        end else if (load_i) begin
            cmd = CMD_LOAD;
        end else if (period_end) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DUTY_W:0] cmp;

        // Per-channel dither state and compare register.
        dsm_pwm_chan #(
            .DUTY_W (DUTY_W),
            .FRAC_W (FRAC_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd),
            .level_i (level_i[g*FLD_W +: LV_W]),
            .cmp_o   (cmp)
        );

        // Per-channel output pin.
        dsm_pwm_compare #(
            .DUTY_W (DUTY_W)
        ) u_cmp (
            .cnt_i (cnt),
            .cmp_i (cmp),
            .pwm_o (pwm_o[g])
        );

        // Spare top bit of each level field is not used.
        assign unused_spare[g] = level_i[g*FLD_W + LV_W];
    end

    assert_zero_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (pwm_o == '0));

endmodule

// File: tb/dsm_pwm_bench.sv
module dsm_pwm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [31:0] level_i = '0;
    logic [1:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    int ph = 0;

    dsm_pwm u_dsm_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .zero_i  (zero_i),
        .level_i (level_i),
        .pwm_o   (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench timer: expected phase position (R1, R2 say period starts at 0).
    always @(posedge clk) begin
        if (!rst_n) ph <= 0;
        else        ph <= (ph + 1) % PER;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ph(input int n);
        while (ph != n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_load(input logic [15:0] a, input logic [15:0] b);
        level_i = {b, a};
        load_i  = 1'b1;
        @(negedge clk);
        load_i  = 1'b0;
    endtask

    // Count high samples of both outputs over one whole period.
    task automatic measure(output int ha, output int hb);
        ha = 0;
        hb = 0;
        wait_ph(0);
        for (int i = 0; i < PER; i++) begin
            ha += int'(pwm_o[0]);
            hb += int'(pwm_o[1]);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int ha, hb;
        level_i = 32'h3000_2000;
        load_i  = 1'b1;
        @(negedge clk);
        load_i  = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R1 outputs during reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        check_eq("R1 phase at reset release", ph, 0);
        measure(ha, hb);
        check_eq("R1 ch0 first period", ha, 0);
        check_eq("R1 ch1 first period", hb, 0);
    endtask

    task automatic t_shape();
        do_reset();
        wait_ph(300);
        pulse_load(16'd10 << 7, 16'd10 << 7);
        wait_ph(9);
        check_eq("R2 phase 9 high", int'(pwm_o), 3);
        @(negedge clk);
        check_eq("R2 phase 10 low", int'(pwm_o), 0);
        wait_ph(501);
        check_eq("R2 phase 501 low", int'(pwm_o), 0);
        @(negedge clk);
        check_eq("R2 phase 502 high", int'(pwm_o), 3);
    endtask

    task automatic t_immediate();
        int ha, hb;
        do_reset();
        wait_ph(5);
        check_eq("R5 low before load", int'(pwm_o[0]), 0);
        pulse_load(16'd100 << 7, 16'd0);
        check_eq("R5 high one clock after load", int'(pwm_o[0]), 1);
        measure(ha, hb);
        check_eq("R5 ch0 width base 100", ha, 200);
        check_eq("R5 ch1 width base 0", hb, 0);
        // R10: level change without load must not move the outputs
        level_i = {16'd40 << 7, 16'd3 << 7};
        measure(ha, hb);
        check_eq("R10 ch0 unchanged", ha, 200);
        check_eq("R10 ch1 unchanged", hb, 0);
    endtask

    task automatic t_pipeline();
        int ha, hb;
        int exp_a[4] = '{40, 40, 42, 42};
        do_reset();
        wait_ph(100);
        pulse_load((16'd20 << 7) | 16'd127, 16'd0);
        for (int p = 0; p < 4; p++) begin
            measure(ha, hb);
            check_eq($sformatf("R7 R6 period %0d ch0 width", p + 1), ha, exp_a[p]);
        end
        check_eq("R7 ch1 stays off", hb, 0);
    endtask

    task automatic t_acc_hold();
        int ha, hb;
        do_reset();
        wait_ph(50);
        pulse_load((16'd5 << 7) | 16'd100, 16'd0);
        measure(ha, hb);
        check_eq("R8 period 1 width", ha, 10);
        wait_ph(50);
        pulse_load((16'd5 << 7) | 16'd100, 16'd0);
        measure(ha, hb);
        check_eq("R8 period 3 width after reload", ha, 10);
        measure(ha, hb);
        check_eq("R8 period 4 carry from kept accumulator", ha, 12);
    endtask

    task automatic t_full_scale();
        int ha, hb;
        int exp_a[3] = '{510, 510, 512};
        do_reset();
        wait_ph(200);
        pulse_load(16'h7FFF, 16'd255 << 7);
        for (int p = 0; p < 3; p++) begin
            measure(ha, hb);
            check_eq($sformatf("R3 period %0d ch0 full scale", p + 1), ha, exp_a[p]);
            check_eq($sformatf("R3 period %0d ch1 compare 255", p + 1), hb, 510);
        end
    endtask

    task automatic t_spare_bit();
        int ha, hb;
        do_reset();
        wait_ph(400);
        pulse_load(16'h8000 | (16'd30 << 7), 16'd30 << 7);
        measure(ha, hb);
        check_eq("R4 ch0 spare bit set", ha, 60);
        check_eq("R4 ch1 reference", hb, 60);
    endtask

    task automatic t_zero();
        int ha, hb;
        do_reset();
        wait_ph(300);
        pulse_load(16'd100 << 7, 16'd50 << 7);
        wait_ph(20);
        check_eq("R9 high before zero", int'(pwm_o), 3);
        zero_i = 1'b1;
        @(negedge clk);
        zero_i = 1'b0;
        check_eq("R9 low one clock after zero", int'(pwm_o), 0);
        measure(ha, hb);
        check_eq("R9 ch0 next period", ha, 0);
        check_eq("R9 ch1 next period", hb, 0);
        measure(ha, hb);
        check_eq("R9 ch0 second period", ha + hb, 0);
        wait_ph(10);
        level_i = {16'd60 << 7, 16'd60 << 7};
        load_i  = 1'b1;
        zero_i  = 1'b1;
        @(negedge clk);
        load_i  = 1'b0;
        zero_i  = 1'b0;
        check_eq("R9 zero wins over load", int'(pwm_o), 0);
    endtask

    task automatic t_dither_sum();
        int ha, hb, sa, sb;
        do_reset();
        wait_ph(10);
        pulse_load((16'd60 << 7) | 16'd37, (16'd3 << 7) | 16'd90);
        measure(ha, hb);
        sa = 0;
        sb = 0;
        for (int p = 0; p < 128; p++) begin
            measure(ha, hb);
            sa += ha;
            sb += hb;
        end
        check_eq("R6 ch0 128-period total fraction 37", sa, 2 * (128 * 60 + 37));
        check_eq("R6 ch1 128-period total fraction 90", sb, 2 * (128 * 3 + 90));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_shape();
        t_immediate();
        t_pipeline();
        t_acc_hold();
        t_full_scale();
        t_spare_bit();
        t_zero();
        t_dither_sum();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule